// File: doc/BRIEF.md
# Prefetch Request Queue

This block holds the block addresses that a prefetch generator wants brought into a cache, in the order they were produced, each with the time at which it becomes ready. When a demand miss is notified, the block first cancels any queued prefetch of the missed block. It can then cancel the newest queued work whose ready time is not earlier than the miss. After that it screens each proposed candidate and appends the ones that survive. The memory side of the cache sees a request line that is high while anything is queued. When that side asks for work, the block hands over the oldest entry.

Duplicates are screened against three places: the cache, the tracker of outstanding misses, and the queue itself. The cache and tracker are reached through lookup ports that the surrounding logic answers in the same cycle. A mode input chooses when the cache is consulted: either as a candidate is inserted, or later when an entry is about to be issued. The queue never refuses a new candidate. When it is full, it drops its oldest entry to make room. Six event counters record what happened to candidates and entries.

Work is serialised. A notification takes one cycle to cancel a matching entry, one cycle per squashed entry, and one cycle per candidate. The block raises `busy` for that whole time. An issue request also runs one cycle per discarded head.

Top module: `pf_queue`

## Requirements
- R1: Every address is reduced to its block address by clearing its low log2(BLK_BYTES) bits before it is compared or stored. Issued addresses therefore always have those bits at zero.
- R2: A notification is dropped without any effect when `note_uncached` is high, or when `note_ifetch` and `cfg_data_only` are both high. In that case `busy` stays low and neither the queue nor any counter changes.
- R3: When the block address of a notified miss equals a queued entry, that entry is removed and `cnt_miss_removed` increments.
- R4: With `cfg_serial_squash` high, the newest entry is removed repeatedly while its ready time is greater than or equal to `note_time`. This step runs after the miss match, and each removal increments `cnt_squashed`.
- R5: Every candidate increments `cnt_identified`. A candidate is then discarded if any of these holds: it hits the cache while `cfg_check_insert` is high; it hits the miss tracker; or it is already queued. Only the last of these increments `cnt_buf_hit`.
- R6: An accepted candidate is appended at the tail with ready time `note_time + delay` (modulo 2^TW). Entries leave in arrival order.
- R7: When a candidate is accepted into a full queue, the oldest entry is dropped first and `cnt_drop_full` increments. The queue never holds more than DEPTH entries.
- R8: With `cfg_check_insert` low, an issue request discards head entries that hit the cache, one per cycle. If the queue runs empty this way, `iss_ack` rises with `iss_ok` low.
- R9: `mem_req` is high exactly while the queue holds an entry. A successful issue (`iss_ack` and `iss_ok`) removes the head and increments `cnt_issued`.
- R10: `head_time` shows the ready time of the oldest entry, or zero when the queue is empty.
- R11: `busy` is high from the cycle after a notification is accepted until its processing ends. A `note_valid` seen while `busy` is high, or while an issue is running, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data_only | input | 1 | Ignore notifications from instruction fetches |
| cfg_serial_squash | input | 1 | Enable tail squash by ready time |
| cfg_check_insert | input | 1 | 1: cache filter at insert; 0: at issue |
| note_valid | input | 1 | Miss notification strobe, taken when idle |
| note_addr | input | AW | Address of the demand miss |
| note_time | input | TW | Time of the miss |
| note_uncached | input | 1 | Miss is to uncacheable space |
| note_ifetch | input | 1 | Miss comes from an instruction fetch |
| note_count | input | NW | Number of valid candidates (clamped to NCAND) |
| note_cand_addr | input | NCAND*AW | Candidate addresses, slot k in bits k*AW upward |
| note_cand_delay | input | NCAND*DW | Per-candidate delay, slot k in bits k*DW upward |
| busy | output | 1 | Notification or issue in progress |
| cache_probe_addr | output | AW | Block address looked up in the cache |
| cache_probe_hit | input | 1 | Same-cycle cache lookup result |
| mshr_probe_addr | output | AW | Block address looked up in the miss tracker |
| mshr_probe_hit | input | 1 | Same-cycle miss tracker lookup result |
| iss_req | input | 1 | Memory side asks for a prefetch, held until `iss_ack` |
| iss_ack | output | 1 | Issue request finished this cycle |
| iss_ok | output | 1 | With `iss_ack`: `iss_addr` is valid |
| iss_addr | output | AW | Issued block address |
| mem_req | output | 1 | Queue is not empty |
| head_time | output | TW | Ready time of the oldest entry, zero if empty |
| cnt_identified | output | CNTW | Candidates seen |
| cnt_buf_hit | output | CNTW | Candidates already queued |
| cnt_drop_full | output | CNTW | Entries dropped for space |
| cnt_miss_removed | output | CNTW | Entries cancelled by a matching miss |
| cnt_squashed | output | CNTW | Entries squashed by ready time |
| cnt_issued | output | CNTW | Entries issued |

## Verification
The hardest state to reach is a single notification that exercises several removal paths at once. It has to remove a matching entry, squash a run of tail entries, and then overflow the queue while screening against its own earlier candidates. Near-empty and full queues both have to occur under every mode combination. The bench sweeps all eight combinations of the three mode inputs over a four-entry queue. It uses a sixteen-block address space and small random ready times, which makes tail times at or above the notification time common and keeps overflow frequent. Cache and tracker contents are reshuffled every few operations so that both insert-time and issue-time filtering see hits. A reference queue in the bench tracks every counter, the head time and each issued address.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MATCH,
      ST_SQUASH,
      ST_CAND,
      ST_ISSUE
   } pfq_state_e;

   typedef enum logic [1:0] {
      SOP_NONE,
      SOP_APPEND,
      SOP_REMOVE,
      SOP_POP_TAIL
   } store_op_e;

   localparam int EV_IDENT  = 0;
   localparam int EV_BUFHIT = 1;
   localparam int EV_FULL   = 2;
   localparam int EV_MISSRM = 3;
   localparam int EV_SQUASH = 4;
   localparam int EV_ISSUE  = 5;
   localparam int EV_COUNT  = 6;
endpackage

// File: rtl/pfq_store.sv
// Compacted age-ordered storage: slot 0 is the oldest entry.
module pfq_store
   import pfq_pkg::*;
#(
   parameter int AW    = 32,
   parameter int TW    = 16,
   parameter int DEPTH = 8,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  store_op_e     op,
   input  logic [IW-1:0] op_idx,
   input  logic [AW-1:0] wr_addr,
   input  logic [TW-1:0] wr_time,
   input  logic [AW-1:0] look_addr,
   output logic          look_hit,
   output logic [IW-1:0] look_idx,
   output logic [CW-1:0] fill,
   output logic [AW-1:0] head_addr,
   output logic [TW-1:0] head_time,
   output logic [TW-1:0] tail_time
);
   logic [AW-1:0] addr_q [DEPTH];
   logic [TW-1:0] time_q [DEPTH];
   logic [AW-1:0] addr_d [DEPTH];
   logic [TW-1:0] time_d [DEPTH];
   logic [CW-1:0] fill_d;
   logic [DEPTH-1:0] match;
   logic          full;

   assign full = (fill == CW'(DEPTH));

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = (CW'(g) < fill) && (addr_q[g] == look_addr);
   end

   always_comb begin
      look_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) look_idx = IW'(i);
      end
   end
   assign look_hit = |match;

   always_comb begin
      tail_time = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (fill == CW'(i + 1)) tail_time = time_q[i];
      end
   end

   assign head_addr = addr_q[0];
   assign head_time = (fill == '0) ? '0 : time_q[0];

   always_comb begin
      addr_d = addr_q;
      time_d = time_q;
      fill_d = fill;
      case (op)
         SOP_APPEND: begin
            if (full) begin
               for (int i = 0; i < DEPTH - 1; i++) begin
                  addr_d[i] = addr_q[i + 1];
                  time_d[i] = time_q[i + 1];
               end
               addr_d[DEPTH-1] = wr_addr;
               time_d[DEPTH-1] = wr_time;
            end else begin
               for (int i = 0; i < DEPTH; i++) begin
                  if (CW'(i) == fill) begin
                     addr_d[i] = wr_addr;
                     time_d[i] = wr_time;
                  end
               end
               fill_d = fill + 1'b1;
            end
         end
         SOP_REMOVE: begin
            for (int i = 0; i < DEPTH - 1; i++) begin
               if (IW'(i) >= op_idx) begin
                  addr_d[i] = addr_q[i + 1];
                  time_d[i] = time_q[i + 1];
               end
            end
            fill_d = fill - 1'b1;
         end
         SOP_POP_TAIL: fill_d = fill - 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            addr_q[i] <= '0;
            time_q[i] <= '0;
         end
      end else begin
         fill   <= fill_d;
         addr_q <= addr_d;
         time_q <= time_d;
      end
   end
endmodule

// File: rtl/pfq_events.sv
module pfq_events #(
   parameter int NEV  = 6,
   parameter int CNTW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NEV-1:0]      bump,
   output logic [NEV*CNTW-1:0] totals
);
   for (genvar g = 0; g < NEV; g++) begin : g_ctr
      logic [CNTW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt_q <= '0;
         else if (bump[g]) cnt_q <= cnt_q + 1'b1;
      end
      assign totals[g*CNTW +: CNTW] = cnt_q;
   end
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
   import pfq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int TW        = 16,
   parameter int DW        = 8,
   parameter int DEPTH     = 8,
   parameter int NCAND     = 4,
   parameter int BLK_BYTES = 64,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int NW = $clog2(NCAND + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_data_only,
   input  logic                cfg_serial_squash,
   input  logic                cfg_check_insert,
   input  logic                note_valid,
   input  logic [AW-1:0]       note_addr,
   input  logic [TW-1:0]       note_time,
   input  logic                note_uncached,
   input  logic                note_ifetch,
   input  logic [NW-1:0]       note_count,
   input  logic [NCAND*AW-1:0] note_cand_addr,
   input  logic [NCAND*DW-1:0] note_cand_delay,
   input  logic                iss_req,
   input  logic                cache_probe_hit,
   input  logic                mshr_probe_hit,
   input  logic                look_hit,
   input  logic [IW-1:0]       look_idx,
   input  logic [CW-1:0]       fill,
   input  logic [AW-1:0]       head_addr,
   input  logic [TW-1:0]       tail_time,
   output store_op_e           op,
   output logic [IW-1:0]       op_idx,
   output logic [AW-1:0]       wr_addr,
   output logic [TW-1:0]       wr_time,
   output logic [AW-1:0]       look_addr,
   output logic [AW-1:0]       cache_probe_addr,
   output logic [AW-1:0]       mshr_probe_addr,
   output logic                busy,
   output logic                iss_ack,
   output logic                iss_ok,
   output logic [EV_COUNT-1:0] bump
);
   localparam logic [AW-1:0] BLK_MASK = ~AW'(BLK_BYTES - 1);

   pfq_state_e    state_q, state_d;
   logic [NW-1:0] idx_q, idx_d, n_q;
   logic [AW-1:0] miss_blk_q;
   logic [TW-1:0] time_q;
   logic [AW-1:0] cand_a_q [NCAND];
   logic [DW-1:0] cand_d_q [NCAND];
   logic [AW-1:0] cur_cand;
   logic [DW-1:0] cur_delay;
   logic          full, dropped;

   assign full    = (fill == CW'(DEPTH));
   assign dropped = note_uncached || (note_ifetch && cfg_data_only);

   always_comb begin
      cur_cand  = '0;
      cur_delay = '0;
      for (int i = 0; i < NCAND; i++) begin
         if (NW'(i) == idx_q) begin
            cur_cand  = cand_a_q[i] & BLK_MASK;
            cur_delay = cand_d_q[i];
         end
      end
   end

   assign look_addr        = (state_q == ST_MATCH) ? miss_blk_q : cur_cand;
   assign cache_probe_addr = (state_q == ST_ISSUE) ? head_addr : cur_cand;
   assign mshr_probe_addr  = cur_cand;
   assign wr_addr          = cur_cand;
   assign wr_time          = time_q + TW'(cur_delay);
   assign busy             = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      op      = SOP_NONE;
      op_idx  = '0;
      bump    = '0;
      iss_ack = 1'b0;
      iss_ok  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (note_valid) begin
               if (!dropped) state_d = ST_MATCH;
            end else if (iss_req) begin
               state_d = ST_ISSUE;
            end
         end
         ST_MATCH: begin
            if (look_hit) begin
               op               = SOP_REMOVE;
               op_idx           = look_idx;
               bump[EV_MISSRM]  = 1'b1;
            end
            state_d = cfg_serial_squash ? ST_SQUASH : ST_CAND;
         end
         ST_SQUASH: begin
            if (fill != '0 && tail_time >= time_q) begin
               op               = SOP_POP_TAIL;
               bump[EV_SQUASH]  = 1'b1;
            end else begin
               state_d = ST_CAND;
            end
         end
         ST_CAND: begin
            if (idx_q == n_q) begin
               state_d = ST_IDLE;
            end else begin
               bump[EV_IDENT] = 1'b1;
               idx_d          = idx_q + 1'b1;
               if (cfg_check_insert && cache_probe_hit) begin
                  op = SOP_NONE;
               end else if (mshr_probe_hit) begin
                  op = SOP_NONE;
               end else if (look_hit) begin
                  bump[EV_BUFHIT] = 1'b1;
               end else begin
                  op             = SOP_APPEND;
                  bump[EV_FULL]  = full;
               end
            end
         end
         ST_ISSUE: begin
            if (fill == '0) begin
               iss_ack = 1'b1;
               state_d = ST_IDLE;
            end else if (!cfg_check_insert && cache_probe_hit) begin
               op = SOP_REMOVE;
            end else begin
               op              = SOP_REMOVE;
               iss_ack         = 1'b1;
               iss_ok          = 1'b1;
               bump[EV_ISSUE]  = 1'b1;
               state_d         = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         n_q        <= '0;
         miss_blk_q <= '0;
         time_q     <= '0;
         for (int i = 0; i < NCAND; i++) begin
            cand_a_q[i] <= '0;
            cand_d_q[i] <= '0;
         end
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
         if (state_q == ST_IDLE && note_valid) begin
            idx_q      <= '0;
            miss_blk_q <= note_addr & BLK_MASK;
            time_q     <= note_time;
            n_q        <= (note_count > NW'(NCAND)) ? NW'(NCAND) : note_count;
            for (int i = 0; i < NCAND; i++) begin
               cand_a_q[i] <= note_cand_addr[i*AW +: AW];
               cand_d_q[i] <= note_cand_delay[i*DW +: DW];
            end
         end
      end
   end
endmodule

// File: rtl/pf_queue.sv
module pf_queue
   import pfq_pkg::*;
#(
   parameter int AW        = 32,
   parameter int TW        = 16,
   parameter int DW        = 8,
   parameter int DEPTH     = 8,
   parameter int NCAND     = 4,
   parameter int BLK_BYTES = 64,
   parameter int CNTW      = 16,
   localparam int NW = $clog2(NCAND + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_data_only,
   input  logic                cfg_serial_squash,
   input  logic                cfg_check_insert,
   input  logic                note_valid,
   input  logic [AW-1:0]       note_addr,
   input  logic [TW-1:0]       note_time,
   input  logic                note_uncached,
   input  logic                note_ifetch,
   input  logic [NW-1:0]       note_count,
   input  logic [NCAND*AW-1:0] note_cand_addr,
   input  logic [NCAND*DW-1:0] note_cand_delay,
   output logic                busy,
   output logic [AW-1:0]       cache_probe_addr,
   input  logic                cache_probe_hit,
   output logic [AW-1:0]       mshr_probe_addr,
   input  logic                mshr_probe_hit,
   input  logic                iss_req,
   output logic                iss_ack,
   output logic                iss_ok,
   output logic [AW-1:0]       iss_addr,
   output logic                mem_req,
   output logic [TW-1:0]       head_time,
   output logic [CNTW-1:0]     cnt_identified,
   output logic [CNTW-1:0]     cnt_buf_hit,
   output logic [CNTW-1:0]     cnt_drop_full,
   output logic [CNTW-1:0]     cnt_miss_removed,
   output logic [CNTW-1:0]     cnt_squashed,
   output logic [CNTW-1:0]     cnt_issued
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (BLK_BYTES < 2 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two of at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (NCAND < 1) begin : g_bad_cand
      $error("NCAND must be at least 1");
   end
   if (DW > TW) begin : g_bad_delay
      $error("DW must not exceed TW");
   end

   store_op_e             op;
   logic [IW-1:0]         op_idx, look_idx;
   logic [AW-1:0]         wr_addr, look_addr, head_addr;
   logic [TW-1:0]         wr_time, tail_time;
   logic                  look_hit;
   logic [CW-1:0]         fill;
   logic [EV_COUNT-1:0]   bump;
   logic [EV_COUNT*CNTW-1:0] totals;

   pfq_ctrl #(
      .AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .NCAND(NCAND), .BLK_BYTES(BLK_BYTES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
      .cfg_check_insert(cfg_check_insert),
      .note_valid(note_valid), .note_addr(note_addr), .note_time(note_time),
      .note_uncached(note_uncached), .note_ifetch(note_ifetch), .note_count(note_count),
      .note_cand_addr(note_cand_addr), .note_cand_delay(note_cand_delay),
      .iss_req(iss_req), .cache_probe_hit(cache_probe_hit), .mshr_probe_hit(mshr_probe_hit),
      .look_hit(look_hit), .look_idx(look_idx), .fill(fill), .head_addr(head_addr),
      .tail_time(tail_time), .op(op), .op_idx(op_idx), .wr_addr(wr_addr), .wr_time(wr_time),
      .look_addr(look_addr), .cache_probe_addr(cache_probe_addr),
      .mshr_probe_addr(mshr_probe_addr), .busy(busy), .iss_ack(iss_ack), .iss_ok(iss_ok),
      .bump(bump)
   );

   pfq_store #(.AW(AW), .TW(TW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .op(op), .op_idx(op_idx), .wr_addr(wr_addr),
      .wr_time(wr_time), .look_addr(look_addr), .look_hit(look_hit), .look_idx(look_idx),
      .fill(fill), .head_addr(head_addr), .head_time(head_time), .tail_time(tail_time)
   );

   pfq_events #(.NEV(EV_COUNT), .CNTW(CNTW)) u_events (
      .clk(clk), .rst_n(rst_n), .bump(bump), .totals(totals)
   );

   assign mem_req          = (fill != '0);
   assign iss_addr         = head_addr;
   assign cnt_identified   = totals[EV_IDENT*CNTW  +: CNTW];
   assign cnt_buf_hit      = totals[EV_BUFHIT*CNTW +: CNTW];
   assign cnt_drop_full    = totals[EV_FULL*CNTW   +: CNTW];
   assign cnt_miss_removed = totals[EV_MISSRM*CNTW +: CNTW];
   assign cnt_squashed     = totals[EV_SQUASH*CNTW +: CNTW];
   assign cnt_issued       = totals[EV_ISSUE*CNTW  +: CNTW];
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
   parameter int AW        = 32,
   parameter int TW        = 16,
   parameter int DEPTH     = 8,
   parameter int BLK_BYTES = 64,
   parameter int CNTW      = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            note_valid,
   input logic            note_uncached,
   input logic            iss_ack,
   input logic            iss_ok,
   input logic [AW-1:0]   iss_addr,
   input logic            mem_req,
   input logic [TW-1:0]   head_time,
   input logic [CNTW-1:0] cnt_issued,
   input logic [CNTW-1:0] cnt_drop_full,
   input logic [CW-1:0]   fill
);
   localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);

   assert_issue_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ack && iss_ok) |-> ((iss_addr & OFF_MASK) == '0));

   assert_uncached_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && note_valid && note_uncached) |=> !busy);

   assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   assert_drop_only_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_drop_full != $past(cnt_drop_full)) |-> (fill == CW'(DEPTH)));

   assert_issue_needs_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ack && iss_ok) |-> mem_req);

   assert_issue_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_ack && iss_ok) |=> (cnt_issued == $past(cnt_issued) + 1'b1));

   assert_empty_head_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (head_time == '0));
endmodule

bind pf_queue pfq_chk #(
   .AW(AW), .TW(TW), .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .CNTW(CNTW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .note_valid(note_valid),
   .note_uncached(note_uncached), .iss_ack(iss_ack), .iss_ok(iss_ok),
   .iss_addr(iss_addr), .mem_req(mem_req), .head_time(head_time),
   .cnt_issued(cnt_issued), .cnt_drop_full(cnt_drop_full), .fill(fill)
);

// File: tb/pf_queue_bench.sv
`timescale 1ns/1ps
module pf_queue_bench;
   localparam int AW = 16, TW = 12, DW = 6, DEPTH = 4, NCAND = 4, BLK = 16, CNTW = 16;
   localparam int NW = $clog2(NCAND + 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, cfg_data_only, cfg_serial_squash, cfg_check_insert;
   logic note_valid, note_uncached, note_ifetch, iss_req;
   logic [AW-1:0] note_addr;
   logic [TW-1:0] note_time;
   logic [NW-1:0] note_count;
   logic [NCAND*AW-1:0] note_cand_addr;
   logic [NCAND*DW-1:0] note_cand_delay;
   logic busy, cache_probe_hit, mshr_probe_hit, iss_ack, iss_ok, mem_req;
   logic [AW-1:0] cache_probe_addr, mshr_probe_addr, iss_addr;
   logic [TW-1:0] head_time;
   logic [CNTW-1:0] cnt_identified, cnt_buf_hit, cnt_drop_full, cnt_miss_removed, cnt_squashed, cnt_issued;

   pf_queue #(.AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .NCAND(NCAND), .BLK_BYTES(BLK), .CNTW(CNTW)) u_pf_queue (
      .clk(clk), .rst_n(rst_n), .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
      .cfg_check_insert(cfg_check_insert), .note_valid(note_valid), .note_addr(note_addr),
      .note_time(note_time), .note_uncached(note_uncached), .note_ifetch(note_ifetch),
      .note_count(note_count), .note_cand_addr(note_cand_addr), .note_cand_delay(note_cand_delay),
      .busy(busy), .cache_probe_addr(cache_probe_addr), .cache_probe_hit(cache_probe_hit),
      .mshr_probe_addr(mshr_probe_addr), .mshr_probe_hit(mshr_probe_hit), .iss_req(iss_req),
      .iss_ack(iss_ack), .iss_ok(iss_ok), .iss_addr(iss_addr), .mem_req(mem_req),
      .head_time(head_time), .cnt_identified(cnt_identified), .cnt_buf_hit(cnt_buf_hit),
      .cnt_drop_full(cnt_drop_full), .cnt_miss_removed(cnt_miss_removed),
      .cnt_squashed(cnt_squashed), .cnt_issued(cnt_issued)
   );

   // environment: cache and miss tracker contents over blocks 0..15
   logic cset [16];
   logic mset [16];
   function automatic logic in_cache(input logic [AW-1:0] a);
      return (a[15:8] == 8'h00) && cset[a[7:4]];
   endfunction
   function automatic logic in_mshr(input logic [AW-1:0] a);
      return (a[15:8] == 8'h00) && mset[a[7:4]];
   endfunction
   always_comb cache_probe_hit = in_cache(cache_probe_addr);
   always_comb mshr_probe_hit  = in_mshr(mshr_probe_addr);

   // reference queue
   int mq_n;
   logic [AW-1:0] mq_a [DEPTH];
   logic [TW-1:0] mq_t [DEPTH];
   int m_cnt [6];
   logic [AW-1:0] nc_a [NCAND];
   logic [DW-1:0] nc_d [NCAND];

   int total = 0, fails = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check(mem_req == (mq_n > 0), "R9", "mem_req", int'(mem_req), int'(mq_n > 0));
      check(head_time == ((mq_n > 0) ? mq_t[0] : '0), "R10", "head_time (R6 stamp)",
            int'(head_time), (mq_n > 0) ? int'(mq_t[0]) : 0);
      check(int'(cnt_identified) == m_cnt[0], "R5", "identified", int'(cnt_identified), m_cnt[0]);
      check(int'(cnt_buf_hit) == m_cnt[1], "R5", "buffer hits", int'(cnt_buf_hit), m_cnt[1]);
      check(int'(cnt_drop_full) == m_cnt[2], "R7", "full drops", int'(cnt_drop_full), m_cnt[2]);
      check(int'(cnt_miss_removed) == m_cnt[3], "R3", "miss removals", int'(cnt_miss_removed), m_cnt[3]);
      check(int'(cnt_squashed) == m_cnt[4], "R4", "squashes", int'(cnt_squashed), m_cnt[4]);
      check(int'(cnt_issued) == m_cnt[5], "R9", "issued", int'(cnt_issued), m_cnt[5]);
   endtask

   task automatic model_remove(input int idx);
      for (int i = idx; i < mq_n - 1; i++) begin
         mq_a[i] = mq_a[i + 1];
         mq_t[i] = mq_t[i + 1];
      end
      mq_n--;
   endtask

   task automatic model_notify(input logic [AW-1:0] a, input logic [TW-1:0] t, input int n);
      logic [AW-1:0] b, c;
      int hit;
      bit dup;
      b = a & 16'hFFF0;
      hit = -1;
      for (int i = 0; i < mq_n; i++) if (mq_a[i] == b) hit = i;
      if (hit >= 0) begin
         model_remove(hit);
         m_cnt[3]++;
      end
      if (cfg_serial_squash) begin
         while (mq_n > 0 && mq_t[mq_n - 1] >= t) begin
            mq_n--;
            m_cnt[4]++;
         end
      end
      for (int k = 0; k < n; k++) begin
         c = nc_a[k] & 16'hFFF0;
         m_cnt[0]++;
         if (cfg_check_insert && in_cache(c)) continue;
         if (in_mshr(c)) continue;
         dup = 0;
         for (int i = 0; i < mq_n; i++) if (mq_a[i] == c) dup = 1;
         if (dup) begin
            m_cnt[1]++;
            continue;
         end
         if (mq_n == DEPTH) begin
            model_remove(0);
            m_cnt[2]++;
         end
         mq_a[mq_n] = c;
         mq_t[mq_n] = t + TW'(nc_d[k]);
         mq_n++;
      end
   endtask

   task automatic do_notify(input logic [AW-1:0] a, input logic [TW-1:0] t,
                            input bit unc, input bit ifx, input int n);
      bit accepted;
      int guard;
      accepted = !(unc || (ifx && cfg_data_only));
      note_addr = a; note_time = t; note_uncached = unc; note_ifetch = ifx;
      note_count = NW'(n);
      for (int k = 0; k < NCAND; k++) begin
         note_cand_addr[k*AW +: AW]  = nc_a[k];
         note_cand_delay[k*DW +: DW] = nc_d[k];
      end
      note_valid = 1'b1;
      @(negedge clk);
      if (accepted) check(busy == 1'b1, "R11", "busy after accepted note", int'(busy), 1);
      else          check(busy == 1'b0, "R2", "busy after dropped note", int'(busy), 0);
      @(negedge clk);   // note_valid held across a busy edge: must be ignored (R11)
      note_valid = 1'b0;
      guard = 0;
      while (busy && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      check(!busy, "R11", "notification finishes", int'(busy), 0);
      if (accepted) model_notify(a, t, n);
      compare_all();
   endtask

   task automatic do_issue();
      bit got, exp_ok;
      logic [AW-1:0] got_addr, exp_addr;
      int guard;
      got = 0; got_addr = '0;
      iss_req = 1'b1;
      guard = 0;
      while (!got && guard < 20) begin
         @(negedge clk);
         if (iss_ack) begin
            got = 1;
            exp_ok = iss_ok;
            got_addr = iss_addr;
         end
         guard++;
      end
      iss_req = 1'b0;
      check(got, "R8", "issue acknowledged", int'(got), 1);
      @(negedge clk);
      // reference
      exp_addr = '0;
      begin
         bit ok_m;
         ok_m = 0;
         while (mq_n > 0 && !ok_m) begin
            if (!cfg_check_insert && in_cache(mq_a[0])) model_remove(0);
            else begin
               exp_addr = mq_a[0];
               model_remove(0);
               m_cnt[5]++;
               ok_m = 1;
            end
         end
         check(exp_ok == ok_m, "R8", "iss_ok", int'(exp_ok), int'(ok_m));
         if (ok_m && exp_ok) begin
            check(got_addr == exp_addr, "R6", "issue order address", int'(got_addr), int'(exp_addr));
            check(got_addr[3:0] == 4'h0, "R1", "issued offset bits", int'(got_addr[3:0]), 0);
         end
      end
      compare_all();
   endtask

   initial begin
      rst_n = 1'b0; note_valid = 1'b0; iss_req = 1'b0; note_addr = '0; note_time = '0;
      note_uncached = 1'b0; note_ifetch = 1'b0; note_count = '0;
      note_cand_addr = '0; note_cand_delay = '0;
      cfg_data_only = 1'b0; cfg_serial_squash = 1'b0; cfg_check_insert = 1'b0;
      for (int i = 0; i < 16; i++) begin cset[i] = 1'b0; mset[i] = 1'b0; end
      for (int mode = 0; mode < 8; mode++) begin
         @(negedge clk);
         rst_n = 1'b0;
         cfg_data_only     = mode[0];
         cfg_serial_squash = mode[1];
         cfg_check_insert  = mode[2];
         mq_n = 0;
         for (int e = 0; e < 6; e++) m_cnt[e] = 0;
         for (int i = 0; i < 16; i++) begin cset[i] = 1'b0; mset[i] = 1'b0; end
         repeat (3) @(negedge clk);
         rst_n = 1'b1;
         @(negedge clk);
         check(busy == 1'b0, "R11", "busy at reset", int'(busy), 0);
         compare_all();
         for (int op = 0; op < 60; op++) begin
            if (op % 8 == 0) begin
               for (int i = 0; i < 16; i++) begin
                  cset[i] = ($urandom % 4) == 0;
                  mset[i] = ($urandom % 6) == 0;
               end
            end
            if (($urandom % 3) == 0) begin
               do_issue();
            end else begin
               for (int k = 0; k < NCAND; k++) begin
                  nc_a[k] = AW'((($urandom % 16) << 4) | ($urandom % 16));
                  nc_d[k] = DW'($urandom % 64);
               end
               do_notify(AW'((($urandom % 16) << 4) | ($urandom % 16)), TW'($urandom % 64),
                         ($urandom % 8) == 0, ($urandom % 4) == 0, int'($urandom % 5));
            end
         end
         // drain: issue until the queue reports empty
         for (int d = 0; d < DEPTH + 1; d++) do_issue();
         check(mem_req == 1'b0, "R9", "drained request line", int'(mem_req), 0);
      end
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule